// File: doc/BRIEF.md
# Dual Byte FIFO with Occupancy Counts and Threshold Interrupts

This block holds the character buffering for one serial channel. It has two byte FIFOs of 64 entries each. The transmit FIFO is filled by the host and drained by the serialiser. The receive FIFO is filled by the deserialiser and drained by the host. Each FIFO has its own push and pop strobes. Each one keeps an occupancy count that software can read, and a threshold that software can program.

The two thresholds are compared in opposite senses. The transmit interrupt is a request for more data, so it stays high while transmit occupancy is below its threshold. The receive interrupt is a request to empty the buffer, so it stays high once receive occupancy reaches its threshold.

A one-bit register port selects a direction. A read returns that direction's count. A write sets that direction's threshold.

Each FIFO is controlled by a three-state fill machine:
- States: EMPTY, PARTIAL and FULL.
- Transitions: *fill* (EMPTY to PARTIAL, on a lone push), *top-off* (PARTIAL to FULL, on a lone push at 63 entries), *drain* (FULL to PARTIAL, on a lone pop) and *exhaust* (PARTIAL to EMPTY, on a lone pop at one entry).
- A push and a pop in the same cycle never move the state.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each FIFO stores up to 64 bytes and returns them in the order they were pushed. The current occupancy (0 to 64) is returned zero-extended on the 8-bit `reg_rdata` while no write is in progress. `reg_sel`=0 selects transmit and `reg_sel`=1 selects receive.
- R2: When `reg_wr` is high at a clock edge, `reg_wdata` becomes the threshold of the direction picked by `reg_sel`. A value above 64 is stored as 64. A threshold can never be read back, because reads always return the count.
- R3: A lone push to a FIFO that holds 64 bytes is discarded. The count stays at 64 and that direction's overflow output rises. The overflow output then stays high until reset.
- R4: A lone pop from an empty FIFO leaves the count at 0 and leaves the pop data output unchanged.
- R5: A push and a pop in the same cycle leave the count unchanged, whatever the fill state. When the FIFO is empty, the pushed byte goes straight to the pop data output. When it is full, the oldest byte is delivered, the new byte is stored, and no overflow is raised.
- R6: `tx_irq` is high exactly when transmit occupancy is strictly less than the transmit threshold.
- R7: `rx_irq` is high exactly when receive occupancy is greater than or equal to the receive threshold.
- R8: After reset both FIFOs are empty, both thresholds are 0, both overflow outputs are 0 and both pop data outputs are 0. As a result `tx_irq` is 0 and `rx_irq` is 1.
- R9: The pop data output is registered. It shows the popped byte from the cycle after the pop, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Push strobe, transmit FIFO |
| tx_push_data | input | 8 | Byte to push, transmit FIFO |
| tx_pop | input | 1 | Pop strobe, transmit FIFO |
| tx_pop_data | output | 8 | Last byte popped, transmit FIFO |
| tx_overflow | output | 1 | Sticky dropped-push flag, transmit |
| tx_irq | output | 1 | Transmit below-threshold interrupt |
| rx_push | input | 1 | Push strobe, receive FIFO |
| rx_push_data | input | 8 | Byte to push, receive FIFO |
| rx_pop | input | 1 | Pop strobe, receive FIFO |
| rx_pop_data | output | 8 | Last byte popped, receive FIFO |
| rx_overflow | output | 1 | Sticky dropped-push flag, receive |
| rx_irq | output | 1 | Receive threshold-reached interrupt |
| reg_wr | input | 1 | Threshold write strobe |
| reg_sel | input | 1 | Direction select: 0 transmit, 1 receive |
| reg_wdata | input | 8 | Threshold value to write |
| reg_rdata | output | 8 | Occupancy of the selected direction |

## Verification
The risky coincidence is a push and a pop on the same FIFO in the same cycle. The bench provokes it on purpose in three places:
- on an empty FIFO, where the pushed byte must pass straight through to the pop data;
- on a full FIFO, where the oldest byte leaves, the new byte is kept and no overflow may appear;
- repeatedly at random depths.

A second coincidence is a threshold write in the same cycle as a count change. After that edge, the interrupt must reflect both the new threshold and the new count. A queue-based model in the bench predicts the count, pop data, overflow and both interrupts for every cycle. The bench compares all of them at each falling edge.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    // Fill state of one FIFO
    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fill_state_e;

    // Sense of the threshold comparison
    typedef enum logic {
        CMP_BELOW = 1'b0,   // irq while count <  threshold
        CMP_REACH = 1'b1    // irq while count >= threshold
    } cmp_mode_e;

    localparam int unsigned REG_W = 8;

endpackage

// File: rtl/fifo_core.sv
module fifo_core
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [DATA_W-1:0]                push_data,
    input  logic                             pop,
    output logic [DATA_W-1:0]                pop_data,
    output logic [$clog2(DEPTH+1)-1:0]       count,
    output logic                             overflow
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    fill_state_e            st_q, st_d;
    logic [DATA_W-1:0]      mem [DEPTH];
    logic [PTR_W-1:0]       wptr_q, rptr_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [DATA_W-1:0]      rd_q;
    logic                   ovf_q;
    logic                   is_empty, is_full;
    logic                   wr_en, rd_en, pass_thru, drop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    // Output decode of the fill state
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (st_q)
            FS_EMPTY: is_empty = 1'b1;
            FS_FULL:  is_full  = 1'b1;
            default:  ;
        endcase
    end

    assign rd_en     = pop && !is_empty;
    assign pass_thru = push && pop && is_empty;
    assign wr_en     = push && !pass_thru && (!is_full || pop);
    assign drop      = push && !pop && is_full;

    // Next-state: fill, top-off, drain, exhaust
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_EMPTY: begin
                if (wr_en) st_d = FS_PART;                       // fill
            end
            FS_PART: begin
                if (wr_en && !rd_en && cnt_q == CNT_W'(DEPTH-1))
                    st_d = FS_FULL;                              // top-off
                else if (rd_en && !wr_en && cnt_q == CNT_W'(1))
                    st_d = FS_EMPTY;                             // exhaust
            end
            FS_FULL: begin
                if (rd_en && !wr_en) st_d = FS_PART;             // drain
            end
            default: st_d = FS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FS_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            rd_q   <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_en) wptr_q <= bump(wptr_q);
            if (rd_en) rptr_q <= bump(rptr_q);
            unique case ({wr_en, rd_en})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
            if (rd_en)          rd_q <= mem[rptr_q];
            else if (pass_thru) rd_q <= push_data;
            if (drop) ovf_q <= 1'b1;
        end
    end

    assign pop_data = rd_q;
    assign count    = cnt_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/trig_unit.sv
module trig_unit
    import uart_fifo_pkg::*;
#(
    parameter cmp_mode_e   MODE  = CMP_BELOW,
    parameter int unsigned CNT_W = 7
) (
    input  logic [CNT_W-1:0] count,
    input  logic [REG_W-1:0] trig,
    output logic             irq
);
    logic [REG_W-1:0] cnt_ext;
    assign cnt_ext = REG_W'(count);

    generate
        if (MODE == CMP_BELOW) begin : g_below
            assign irq = cnt_ext < trig;
        end else begin : g_reach
            assign irq = cnt_ext >= trig;
        end
    endgenerate

endmodule

// File: rtl/fifo_regs.sv
module fifo_regs
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    output logic [REG_W-1:0] reg_rdata,
    output logic [REG_W-1:0] tx_trig,
    output logic [REG_W-1:0] rx_trig
);
    localparam logic [REG_W-1:0] LIMIT = REG_W'(DEPTH);

    logic [REG_W-1:0] tx_trig_q, rx_trig_q, wval;

    assign wval = (reg_wdata > LIMIT) ? LIMIT : reg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_trig_q <= '0;
            rx_trig_q <= '0;
        end else if (reg_wr) begin
            if (reg_sel) rx_trig_q <= wval;
            else         tx_trig_q <= wval;
        end
    end

    assign reg_rdata = reg_sel ? REG_W'(rx_count) : REG_W'(tx_count);
    assign tx_trig   = tx_trig_q;
    assign rx_trig   = rx_trig_q;

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    output logic              tx_overflow,
    output logic              tx_irq,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic              rx_overflow,
    output logic              rx_irq,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic [REG_W-1:0] tx_trig, rx_trig;

    fifo_core #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .count     (tx_cnt),
        .overflow  (tx_overflow)
    );

    fifo_core #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .count     (rx_cnt),
        .overflow  (rx_overflow)
    );

    fifo_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .tx_count  (tx_cnt),
        .rx_count  (rx_cnt),
        .reg_rdata (reg_rdata),
        .tx_trig   (tx_trig),
        .rx_trig   (rx_trig)
    );

    trig_unit #(.MODE(CMP_BELOW), .CNT_W(CNT_W)) u_tx_trig (
        .count (tx_cnt),
        .trig  (tx_trig),
        .irq   (tx_irq)
    );

    trig_unit #(.MODE(CMP_REACH), .CNT_W(CNT_W)) u_rx_trig (
        .count (rx_cnt),
        .trig  (rx_trig),
        .irq   (rx_irq)
    );

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tx_push,
    input logic                       tx_pop,
    input logic                       rx_push,
    input logic                       rx_pop,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic [7:0]                 tx_trig,
    input logic [7:0]                 rx_trig,
    input logic                       tx_overflow,
    input logic                       rx_overflow,
    input logic [DATA_W-1:0]          tx_pop_data,
    input logic [DATA_W-1:0]          rx_pop_data,
    input logic                       tx_irq,
    input logic                       rx_irq
);
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= DEPTH) && (rx_cnt <= DEPTH));

    assert_trig_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_trig <= DEPTH) && (rx_trig <= DEPTH));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overflow |=> tx_overflow) and (rx_overflow |=> rx_overflow));

    assert_tx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_pop && tx_cnt == DEPTH) |=> (tx_overflow && $stable(tx_cnt)));

    assert_rx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && rx_cnt == DEPTH) |=> (rx_overflow && $stable(rx_cnt)));

    assert_tx_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !tx_push && tx_cnt == 0) |=> ($stable(tx_pop_data) && tx_cnt == 0));

    assert_rx_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && rx_cnt == 0) |=> ($stable(rx_pop_data) && rx_cnt == 0));

    assert_tx_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_pop) |=> $stable(tx_cnt));

    assert_rx_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_pop) |=> $stable(rx_cnt));

    assert_tx_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq == (8'(tx_cnt) < tx_trig));

    assert_rx_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (8'(rx_cnt) >= rx_trig));

    assert_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_pop |=> $stable(tx_pop_data)) and (!rx_pop |=> $stable(rx_pop_data)));

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_push     (tx_push),
    .tx_pop      (tx_pop),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .tx_cnt      (tx_cnt),
    .rx_cnt      (rx_cnt),
    .tx_trig     (tx_trig),
    .rx_trig     (rx_trig),
    .tx_overflow (tx_overflow),
    .rx_overflow (rx_overflow),
    .tx_pop_data (tx_pop_data),
    .rx_pop_data (rx_pop_data),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq)
);

// File: tb/uart_fifo_pair_tb.sv
`timescale 1ns/1ps
module uart_fifo_pair_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_push, tx_pop, rx_push, rx_pop, reg_wr, reg_sel;
    logic [7:0] tx_push_data, rx_push_data, reg_wdata;
    logic [7:0] tx_pop_data, rx_pop_data, reg_rdata;
    logic       tx_overflow, rx_overflow, tx_irq, rx_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    logic [7:0] m_txq[$];
    logic [7:0] m_rxq[$];
    bit         m_txovf = 0, m_rxovf = 0;
    logic [7:0] m_txpd = 8'h00, m_rxpd = 8'h00;
    int         m_txtrig = 0, m_rxtrig = 0;

    always #2.5 clk = ~clk;

    uart_fifo_pair u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_overflow(tx_overflow), .tx_irq(tx_irq),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_overflow(rx_overflow), .rx_irq(rx_irq),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic mdl(ref logic [7:0] q[$], ref bit ovf, ref logic [7:0] pd,
                       input bit push, input logic [7:0] d, input bit pop);
        if (push && pop) begin
            if (q.size() == 0) pd = d;
            else begin pd = q.pop_front(); q.push_back(d); end
        end else if (push) begin
            if (q.size() == 64) ovf = 1;
            else q.push_back(d);
        end else if (pop) begin
            if (q.size() > 0) pd = q.pop_front();
        end
    endtask

    task automatic compare_all();
        int cnt;
        cnt = reg_sel ? m_rxq.size() : m_txq.size();
        chk("R1 count", int'(reg_rdata), cnt);
        chk("R6 tx_irq", int'(tx_irq), int'(m_txq.size() < m_txtrig));
        chk("R7 rx_irq", int'(rx_irq), int'(m_rxq.size() >= m_rxtrig));
        chk("R3 tx_overflow", int'(tx_overflow), int'(m_txovf));
        chk("R3 rx_overflow", int'(rx_overflow), int'(m_rxovf));
        chk("R9 tx_pop_data", int'(tx_pop_data), int'(m_txpd));
        chk("R9 rx_pop_data", int'(rx_pop_data), int'(m_rxpd));
    endtask

    // One clock: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(input bit tp, input logic [7:0] td, input bit tpo,
                        input bit rp, input logic [7:0] rd, input bit rpo,
                        input bit wr, input bit sel, input logic [7:0] wd);
        int v;
        tx_push = tp; tx_push_data = td; tx_pop = tpo;
        rx_push = rp; rx_push_data = rd; rx_pop = rpo;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        mdl(m_txq, m_txovf, m_txpd, tp, td, tpo);
        mdl(m_rxq, m_rxovf, m_rxpd, rp, rd, rpo);
        if (wr) begin
            v = (int'(wd) > 64) ? 64 : int'(wd);
            if (sel) m_rxtrig = v; else m_txtrig = v;
        end
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; reg_wr = 0;
        compare_all();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        tx_push_data = 0; rx_push_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8 reset state
        reg_sel = 0; #0.5; chk("R8 tx count", int'(reg_rdata), 0);
        reg_sel = 1; #0.5; chk("R8 rx count", int'(reg_rdata), 0);
        chk("R8 tx_irq", int'(tx_irq), 0);
        chk("R8 rx_irq", int'(rx_irq), 1);
        chk("R8 overflow", int'(tx_overflow | rx_overflow), 0);
        chk("R8 pop data", int'(tx_pop_data | rx_pop_data), 0);
        @(negedge clk);

        // R2 threshold writes, R6/R7 reaction
        step(0,0,0, 0,0,0, 1,0,8'd10);
        chk("R6 tx_irq after trig 10", int'(tx_irq), 1);
        chk("R2 read returns count not trig", int'(reg_rdata), 0);
        step(0,0,0, 0,0,0, 1,1,8'd5);
        chk("R7 rx_irq below trig", int'(rx_irq), 0);

        // R1 fill both
        for (int i = 0; i < 64; i++)
            step(1,8'(i*3+1),0, 1,8'(255-i),0, 0,i[0],0);
        step(0,0,0, 0,0,0, 0,0,0);
        chk("R1 tx full count", int'(reg_rdata), 64);
        chk("R6 tx_irq at 64", int'(tx_irq), 0);
        chk("R7 rx_irq at 64", int'(rx_irq), 1);

        // R3 overflow
        step(1,8'hAA,0, 1,8'hBB,0, 0,0,0);
        chk("R3 tx ovf set", int'(tx_overflow), 1);
        chk("R3 tx count held", int'(reg_rdata), 64);
        chk("R3 rx ovf set", int'(rx_overflow), 1);

        // R5 push and pop together at full
        step(1,8'h77,1, 0,0,0, 0,0,0);
        chk("R5 full pair count", int'(reg_rdata), 64);
        chk("R5 full pair data", int'(tx_pop_data), 1);

        // R1/R9 drain tx in order, with threshold write coinciding
        for (int i = 0; i < 64; i++)
            step(0,0,1, 0,0,0, (i == 30),0,8'd40);

        // R4 pop on empty
        step(0,0,1, 0,0,0, 0,0,0);
        chk("R4 empty pop count", int'(reg_rdata), 0);
        chk("R4 empty pop data", int'(tx_pop_data), 16'h77);

        // R5 pass-through at empty
        step(1,8'h5C,1, 0,0,0, 0,0,0);
        chk("R5 empty pair data", int'(tx_pop_data), 8'h5C);
        chk("R5 empty pair count", int'(reg_rdata), 0);

        // R2 clamp of oversize thresholds
        step(0,0,0, 0,0,0, 1,1,8'd200);
        chk("R2 rx clamp 64, count 64", int'(rx_irq), 1);
        step(0,0,0, 0,0,1, 0,1,0);
        chk("R2 rx clamp 64, count 63", int'(rx_irq), 0);
        step(0,0,0, 0,0,0, 1,0,8'd255);
        chk("R2 tx clamp 64, count 0", int'(tx_irq), 1);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            int bias;
            bias = (n / 500) % 2 ? 30 : 70;
            step($urandom_range(99) < bias, 8'($urandom), $urandom_range(99) < 50,
                 $urandom_range(99) < bias, 8'($urandom), $urandom_range(99) < 50,
                 $urandom_range(99) < 4, 1'($urandom), 8'($urandom_range(80)));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule